// File: doc/BRIEF.md
# Packed-FIFO Audio Serial Transmitter

This block is the transmit half of a two-channel audio serial port. A bus master pushes 32-bit words into an eight-entry FIFO. The block unpacks PCM samples from those words and sends them MSB first on a bit clock, a word-select line and a serial data line, using the common two-channel serial audio alignment. The sample width can be 8, 16 or 32 bits, and the output can be stereo or mono. The length of each word-select phase is set in bit-clock periods.

The bit clock is not generated here. A one-cycle `bclk_tick` input marks each half period of the bit clock, and the block toggles `sck` on every tick. Start and stop pulses move the port between running and muted. While muted, the FIFO ignores writes and is not drained, and `sd` is held at zero, but `sck` and `ws` keep running. Any change to the width, channel mode or half-period inputs stops the port and empties the FIFO. Three service-request outputs, one interrupt and two DMA requests, each compare the FIFO level with a threshold of their own.

Top module: `pcm_tx_port`

## Requirements
- R1: The FIFO holds 8 words of 32 bits. `level` reads 0 to 8. A write is stored only while the port is running and the FIFO is not full, so a write to a full FIFO is dropped.
- R2: Each of `irq`, `dma1_req` and `dma2_req` is 1 exactly when `level` is less than or equal to its own threshold input.
- R3: A `start` pulse unmutes the port. A `stop` pulse mutes it. While muted, writes are ignored, no entry is consumed, `sd` stays 0, and `sck` and `ws` keep toggling.
- R4: Any change on `cfg_width`, `cfg_mono` or `cfg_half` mutes the port, empties the FIFO and restarts the frame, which begins with the left phase.
- R5: A `fifo_clr` pulse empties the FIFO and leaves the running state unchanged.
- R6: `sck` toggles on every `bclk_tick`. `ws` and `sd` change only when `sck` falls. `ws` is 0 for the left channel and 1 for the right channel, and each phase lasts `cfg_half` bit periods.
- R7: The width code is `cfg_width` = 00 for 8 bits, 01 for 16 bits and 11 for 32 bits. In each phase, the first bit period after a `ws` change carries 0. The next W bit periods carry the sample MSB first, and all remaining bit periods carry 0. A full sample needs `cfg_half` of at least W+1.
- R8: In 8-bit or 16-bit stereo (`cfg_mono` = 0), one entry makes one frame. The left sample is bits [W-1:0] and the right sample is bits [2W-1:W].
- R9: In 32-bit stereo, each frame takes two entries. The first entry is the left sample and the second is the right sample.
- R10: In mono (`cfg_mono` = 1), one entry makes one frame. Bits [W-1:0] are sent in both the left and the right phase.
- R11: When the FIFO is empty at a phase start, that phase sends zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 2 | Sample width code |
| cfg_mono | input | 1 | 1 = mono, 0 = stereo |
| cfg_half | input | HW (6) | Word-select phase length in bit periods |
| start | input | 1 | Pulse: unmute and accept writes |
| stop | input | 1 | Pulse: mute and refuse writes |
| fifo_clr | input | 1 | Pulse: empty the FIFO |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word |
| bclk_tick | input | 1 | Bit-clock half-period enable |
| thr_irq | input | LW (4) | Interrupt level threshold |
| thr_dma1 | input | LW (4) | First DMA request threshold |
| thr_dma2 | input | LW (4) | Second DMA request threshold |
| level | output | LW (4) | Current FIFO fill level |
| irq | output | 1 | Interrupt request |
| dma1_req | output | 1 | First DMA request |
| dma2_req | output | 1 | Second DMA request |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |

## Verification
Two states are hard to reach from the ports: a frame boundary that meets an empty FIFO at a known point in the stream, and a FIFO that overflows before any entry has been consumed. The bench reaches both the same way. It stops the bit ticks, forces a configuration change so the frame restarts at a known phase, starts the port, and writes a burst of up to ten random entries. Only then does it release the ticks. A receiver model in the bench rebuilds each phase from the rising `sck` edges. It compares the recovered words with the unpacked burst, and it checks that dropped entries never appear and that the phases after the last stored entry are zero.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int WORD = 32;
  localparam logic [1:0] WC8  = 2'b00;
  localparam logic [1:0] WC16 = 2'b01;
  localparam logic [1:0] WC32 = 2'b11;

  // Pick one sample field out of a FIFO word and left-align it for MSB-first shifting.
  function automatic logic [WORD-1:0] lane_align(input logic [WORD-1:0] e,
                                                 input logic [1:0] w,
                                                 input logic upper);
    case (w)
      WC8:     return upper ? {e[15:8], 24'h0} : {e[7:0], 24'h0};
      WC32:    return e;
      default: return upper ? {e[31:16], 16'h0} : {e[15:0], 16'h0};
    endcase
  endfunction

  // Only 32-bit stereo spreads one frame over two entries.
  function automatic logic two_entry_frame(input logic [1:0] w, input logic mono);
    return (w == WC32) && !mono;
  endfunction

  function automatic logic level_hit(input int unsigned lvl, input int unsigned thr);
    return lvl <= thr;
  endfunction
endpackage

// File: rtl/pcm_tx_fifo.sv
module pcm_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic          full, do_w, do_r;

  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_w  = wr && !full;
  assign do_r  = rd && !empty;
  assign rdata = mem[rptr];
  assign level = cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_w && !clr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_w) wptr <= bump(wptr);
      if (do_r) rptr <= bump(rptr);
      cnt <= cnt + LW'(do_w) - LW'(do_r);
    end
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(DEPTH));
  a_r1_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !rd && !clr) |=> (cnt == LW'(DEPTH)));
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt))));
endmodule

// File: rtl/pcm_tx_serial.sv
module pcm_tx_serial
  import pcm_tx_pkg::*;
#(
  parameter int HW = 6,
  localparam int CW = HW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            tick,
  input  logic [HW-1:0]   half,
  input  logic [1:0]      width,
  input  logic            mono,
  input  logic            running,
  input  logic            fifo_empty,
  input  logic [WORD-1:0] fifo_data,
  output logic            pop,
  output logic            sck,
  output logic            ws,
  output logic            sd
);
  logic            sck_q, ws_q, sd_q;
  logic [CW-1:0]   cnt, cnt_last, cnt_nx;
  logic [WORD-1:0] sh, hold_r;
  logic            fall_ev, at_left, at_right, pair32, have;

  assign fall_ev  = tick && sck_q;
  assign cnt_last = {half, 1'b0} - 1'b1;
  assign cnt_nx   = (cnt >= cnt_last) ? '0 : cnt + 1'b1;
  assign at_left  = (cnt_nx == '0);
  assign at_right = (cnt_nx == {1'b0, half});
  assign pair32   = two_entry_frame(width, mono);
  assign have     = running && !fifo_empty;
  assign pop      = fall_ev && have && (at_left || (at_right && pair32));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      ws_q   <= 1'b1;
      sd_q   <= 1'b0;
      cnt    <= '1;
      sh     <= '0;
      hold_r <= '0;
    end else if (restart) begin
      sck_q  <= 1'b0;
      ws_q   <= 1'b1;
      sd_q   <= 1'b0;
      cnt    <= '1;
      sh     <= '0;
      hold_r <= '0;
    end else begin
      if (tick) sck_q <= ~sck_q;
      if (fall_ev) begin
        cnt  <= cnt_nx;
        ws_q <= (cnt_nx >= {1'b0, half});
        if (at_left) begin
          sd_q   <= 1'b0;
          sh     <= have ? lane_align(fifo_data, width, 1'b0) : '0;
          hold_r <= (have && !pair32) ? lane_align(fifo_data, width, !mono) : '0;
        end else if (at_right) begin
          sd_q <= 1'b0;
          sh   <= pair32 ? (have ? fifo_data : '0) : hold_r;
        end else begin
          sd_q <= sh[WORD-1];
          sh   <= {sh[WORD-2:0], 1'b0};
        end
      end
    end
  end

  assign sck = sck_q;
  assign ws  = ws_q;
  assign sd  = sd_q && running;

  a_r6_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_ev && !restart) |=> $stable(ws_q));
  a_r6_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_ev && !restart) |=> $stable(sd_q));
  a_r7_gap_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && !restart && (at_left || at_right)) |=> !sd_q);
endmodule

// File: rtl/pcm_tx_req.sv
module pcm_tx_req
  import pcm_tx_pkg::*;
#(
  parameter int LW = 4,
  parameter int N  = 3
) (
  input  logic [LW-1:0]        level,
  input  logic [N-1:0][LW-1:0] thr,
  output logic [N-1:0]         req
);
  for (genvar i = 0; i < N; i++) begin : g_req
    assign req[i] = level_hit(int'(level), int'(thr[i]));
  end
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HW    = 6,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int CFGW = HW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_mono,
  input  logic [HW-1:0] cfg_half,
  input  logic          start,
  input  logic          stop,
  input  logic          fifo_clr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          bclk_tick,
  input  logic [LW-1:0] thr_irq,
  input  logic [LW-1:0] thr_dma1,
  input  logic [LW-1:0] thr_dma2,
  output logic [LW-1:0] level,
  output logic          irq,
  output logic          dma1_req,
  output logic          dma2_req,
  output logic          sck,
  output logic          ws,
  output logic          sd
);
  logic [CFGW-1:0] cfg_now, cfg_prev;
  logic            cfg_seen, cfg_chg, running, fifo_wr, fifo_flush;
  logic            pop, fifo_empty;
  logic [31:0]     head;
  logic [2:0]      req;

  assign cfg_now    = {cfg_width, cfg_mono, cfg_half};
  assign cfg_chg    = cfg_seen && (cfg_now != cfg_prev);
  assign fifo_wr    = wr_en && running && !cfg_chg;
  assign fifo_flush = fifo_clr || cfg_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_prev <= '0;
      cfg_seen <= 1'b0;
      running  <= 1'b0;
    end else begin
      cfg_prev <= cfg_now;
      cfg_seen <= 1'b1;
      if (cfg_chg)    running <= 1'b0;
      else if (stop)  running <= 1'b0;
      else if (start) running <= 1'b1;
    end
  end

  pcm_tx_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_flush), .wr(fifo_wr), .wdata(wr_data),
    .rd(pop), .rdata(head), .level(level), .empty(fifo_empty)
  );

  pcm_tx_serial #(.HW(HW)) u_ser (
    .clk(clk), .rst_n(rst_n), .restart(cfg_chg), .tick(bclk_tick), .half(cfg_half),
    .width(cfg_width), .mono(cfg_mono), .running(running), .fifo_empty(fifo_empty),
    .fifo_data(head), .pop(pop), .sck(sck), .ws(ws), .sd(sd)
  );

  pcm_tx_req #(.LW(LW), .N(3)) u_req (
    .level(level), .thr({thr_dma2, thr_dma1, thr_irq}), .req(req)
  );

  assign irq      = req[0];
  assign dma1_req = req[1];
  assign dma2_req = req[2];

  a_r4_cfg_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!running && (level == '0)));
  a_r3_muted_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !fifo_flush) |=> $stable(level));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && !cfg_chg) |=> ((level == '0) && (running == $past(running || start) && !$past(stop))));
endmodule

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb;
  localparam int HW = 6;
  localparam int LW = 4;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_width = 2'b00;
  logic cfg_mono = 1'b0;
  logic [HW-1:0] cfg_half = 6'd9;
  logic start = 1'b0, stop = 1'b0, fifo_clr = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic bclk_tick = 1'b0;
  logic [LW-1:0] thr_irq = 4'd2, thr_dma1 = 4'd5, thr_dma2 = 4'd8;
  logic [LW-1:0] level;
  logic irq, dma1_req, dma2_req, sck, ws, sd;

  pcm_tx_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_mono(cfg_mono), .cfg_half(cfg_half),
    .start(start), .stop(stop), .fifo_clr(fifo_clr), .wr_en(wr_en), .wr_data(wr_data),
    .bclk_tick(bclk_tick), .thr_irq(thr_irq), .thr_dma1(thr_dma1), .thr_dma2(thr_dma2),
    .level(level), .irq(irq), .dma1_req(dma1_req), .dma2_req(dma2_req),
    .sck(sck), .ws(ws), .sd(sd)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bit tick generator
  bit tick_on = 1'b0;
  int tdiv = 0;
  always @(negedge clk) begin
    if (tick_on) begin
      tdiv = (tdiv + 1) % TDIV;
      bclk_tick <= (tdiv == 0);
    end else begin
      tdiv = 0;
      bclk_tick <= 1'b0;
    end
  end

  // receiver model
  bit dec_on = 1'b0;
  int dec_w = 8;
  int exp_half = 9;
  logic [31:0] rx_w [0:255];
  int rx_n, per_bad, pad_bad, slot;
  bit started;
  logic last_ws, psck;
  logic [31:0] acc;
  always @(negedge clk) begin
    if (!dec_on) begin
      rx_n = 0; per_bad = 0; pad_bad = 0; started = 0; slot = 0;
      last_ws = 1'b1; acc = '0; psck = sck;
    end else begin
      if (sck && !psck) begin
        if (ws !== last_ws) begin
          if (started) begin
            if (rx_n < 256) rx_w[rx_n] = acc;
            rx_n++;
            if (slot + 1 != exp_half) per_bad++;
          end
          started = 1; last_ws = ws; slot = 0; acc = '0;
          if (sd) pad_bad++;
        end else begin
          slot++;
          if (slot <= dec_w) acc[dec_w - slot] = sd;
          else if (sd) pad_bad++;
        end
      end
      psck = sck;
    end
  end

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'b00) ? 8 : (c == 2'b11) ? 32 : 16;
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
  endfunction

  task automatic tick_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1; @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1; @(negedge clk) stop = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic m, input int h);
    @(negedge clk) begin cfg_width = w; cfg_mono = m; cfg_half = HW'(h + 1); end
    @(negedge clk) cfg_half = HW'(h);
    tick_clk(2);
  endtask

  logic [31:0] exp_w [0:31];
  int exp_n;

  task automatic run_mode(input string tag, input logic [1:0] wc, input logic m, input int h, input int n);
    int w;
    int kept;
    int frames;
    logic [31:0] mk;
    logic [31:0] e;
    w = wbits(wc);
    mk = wmask(w);
    tick_on = 1'b0;
    set_cfg(wc, m, h);
    pulse_start();
    exp_n = 0;
    kept = (n > 8) ? 8 : n;
    for (int i = 0; i < n; i++) begin
      e = $urandom;
      write_word(e);
      if (i < 8) begin
        if (m) begin
          exp_w[exp_n] = e & mk; exp_w[exp_n + 1] = e & mk; exp_n += 2;
        end else if (w == 32) begin
          exp_w[exp_n] = e; exp_n += 1;
        end else begin
          exp_w[exp_n] = e & mk; exp_w[exp_n + 1] = (e >> w) & mk; exp_n += 2;
        end
      end
    end
    tick_clk(1);
    chk("R1", {tag, " level after burst"}, level, kept);
    dec_w = w; exp_half = h;
    dec_on = 1'b0; tick_clk(1); dec_on = 1'b1;
    tick_on = 1'b1;
    frames = (exp_n + 1) / 2 + 3;
    tick_clk(frames * h * 2 * 2 * TDIV + 20);
    tick_on = 1'b0;
    tick_clk(2);
    chk("R6", {tag, " enough phases"}, (rx_n >= exp_n + 2), 1);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      chk(m ? "R10" : (w == 32 ? "R9" : "R8"), $sformatf("%s word %0d", tag, i), rx_w[i], exp_w[i]);
    if (rx_n >= exp_n + 2) begin
      chk("R11", {tag, " underflow word a"}, rx_w[exp_n], 0);
      chk("R11", {tag, " underflow word b"}, rx_w[exp_n + 1], 0);
    end
    chk("R6", {tag, " ws phase length"}, per_bad, 0);
    chk("R7", {tag, " zero padding bits"}, pad_bad, 0);
    chk("R11", {tag, " fifo drained"}, level, 0);
    dec_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    tick_clk(4);
    chk("R1", "reset level", level, 0);
    chk("R2", "reset irq", irq, 1);
    chk("R6", "reset sck", sck, 0);
    chk("R6", "reset ws", ws, 1);
    chk("R3", "reset sd", sd, 0);
    @(negedge clk) rst_n = 1'b1;
    tick_clk(3);

    // R2: thresholds vs level
    tick_on = 1'b0;
    set_cfg(2'b01, 1'b0, 17);
    pulse_start();
    for (int k = 0; k <= 8; k++) begin
      if (k > 0) write_word($urandom);
      tick_clk(1);
      chk("R2", $sformatf("irq at level %0d", k), irq, (k <= 2));
      chk("R2", $sformatf("dma1 at level %0d", k), dma1_req, (k <= 5));
      chk("R2", $sformatf("dma2 at level %0d", k), dma2_req, (k <= 8));
    end
    write_word(32'hDEAD_BEEF);
    tick_clk(1);
    chk("R1", "write to full dropped", level, 8);

    // R5: clear keeps running
    @(negedge clk) fifo_clr = 1'b1; @(negedge clk) fifo_clr = 1'b0;
    tick_clk(1);
    chk("R5", "level after clear", level, 0);
    write_word(32'h1);
    tick_clk(1);
    chk("R5", "still running after clear", level, 1);

    // R4: config change flushes and mutes
    @(negedge clk) cfg_mono = 1'b1;
    tick_clk(2);
    chk("R4", "level after cfg change", level, 0);
    write_word(32'h2);
    tick_clk(1);
    chk("R4", "write ignored after cfg change", level, 0);

    // R3: muted port
    set_cfg(2'b00, 1'b0, 9);
    pulse_start();
    for (int i = 0; i < 3; i++) write_word(32'hFFFF_FFFF);
    pulse_stop();
    write_word(32'hFFFF_FFFF);
    write_word(32'hFFFF_FFFF);
    tick_clk(1);
    chk("R3", "writes ignored while muted", level, 3);
    dec_w = 8; exp_half = 9;
    dec_on = 1'b0; tick_clk(1); dec_on = 1'b1; tick_on = 1'b1;
    tick_clk(3 * 9 * 2 * 2 * TDIV);
    tick_on = 1'b0; tick_clk(2);
    chk("R3", "ws keeps toggling while muted", (rx_n >= 4), 1);
    chk("R3", "muted data zero", pad_bad, 0);
    for (int i = 0; i < 4 && i < rx_n; i++) chk("R3", $sformatf("muted word %0d", i), rx_w[i], 0);
    chk("R3", "no entry consumed while muted", level, 3);
    dec_on = 1'b0;

    // playback modes
    run_mode("st8", 2'b00, 1'b0, 9, 6);
    run_mode("st16", 2'b01, 1'b0, 17, 5);
    run_mode("st32", 2'b11, 1'b0, 33, 6);
    run_mode("mo8", 2'b00, 1'b1, 10, 4);
    run_mode("mo16", 2'b01, 1'b1, 20, 3);
    run_mode("mo32", 2'b11, 1'b1, 35, 3);
    for (int t = 0; t < 3; t++) begin
      logic [1:0] wc;
      int r;
      r = $urandom % 3;
      wc = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
      run_mode($sformatf("rnd%0d", t), wc, 1'($urandom % 2), wbits(wc) + 1 + int'($urandom % 4),
               (t == 0) ? 10 : 1 + int'($urandom % 8));
    end
    run_mode("full8", 2'b00, 1'b0, 9, 10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule